// File: doc/BRIEF.md
# Reservation Tracker for Atomic Load/Store-Conditional Pairs

This block stands in front of a data cache and holds the one memory reservation used by atomic read-modify-write sequences. It accepts one request per cycle while idle. A request is an ordinary load, an ordinary store, a load-reserve or a store-conditional, and each carries a byte address.

A load-reserve arms the reservation for the 64-byte line that holds its address. A store-conditional is checked against that line. When it matches, the block lets the cache write and the bus cycle start, and it waits for the bus acknowledge. When it does not match, the block cancels the store, so no write and no bus cycle happen, and it reports failure on the next cycle.

Every completion is a one-cycle pulse. It carries a condition-record flag, which is set only for store-conditionals, and a stored flag, which is set only for a store-conditional that succeeded. The cache arrays, the bus and the update of the condition register are outside the block.

Top module: `resv_tracker`

## Requirements
- R1: The reservation matches on line granularity: two addresses match when bits [63:6] are equal, and bits [5:0] are ignored.
- R2: An accepted load-reserve (req_kind = 2) makes the reservation valid with its line address, and replaces any earlier reservation.
- R3: An accepted store-conditional (req_kind = 3) that misses the reservation asserts neither cache_wr_en nor bus_start. A miss is either no valid reservation or a different line.
- R4: A store-conditional that missed completes on the cycle after it is accepted, with done_valid=1, done_rc=1 and done_stored=0.
- R5: A store-conditional that matched asserts cache_wr_en and bus_start in its accept cycle. It completes on the cycle after bus_ack is sampled, with done_rc=1 and done_stored=1.
- R6: Reset leaves the reservation invalid, busy low and done_valid low.
- R7: Every accepted store-conditional clears the reservation, whether it succeeds or fails.
- R8: Ordinary loads (req_kind = 0) and ordinary stores (req_kind = 1) complete with done_rc=0 and done_stored=0. A load completes on the next cycle. A store asserts cache_wr_en and bus_start when accepted and completes on the cycle after bus_ack.
- R9: Ordinary loads and stores leave the reservation unchanged, even when they hit the reserved line.
- R10: While busy is high, waiting for bus_ack, requests are not accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 load-reserve, 3 store-conditional |
| req_addr | input | 64 | Byte address of the request |
| bus_ack | input | 1 | Bus acknowledge for the outstanding write |
| busy | output | 1 | Waiting for a write acknowledge; requests ignored |
| cache_wr_en | output | 1 | Permit the cache write for the accepted store |
| bus_start | output | 1 | Start the bus write cycle for the accepted store |
| done_valid | output | 1 | Completion pulse |
| done_rc | output | 1 | Completion updates the condition record |
| done_stored | output | 1 | Conditional store took effect |

## Verification
On every cycle, the assertions check four things. A cancelled store-conditional never reaches the cache write or the bus. Its failure completion follows exactly one cycle later. A stored flag never appears without the condition-record flag. The reservation bit follows reset, load-reserve and store-conditional as required. What only the bench's scenarios can show is which addresses count as a match on line granularity, and that a newer load-reserve replaces the older one. The scenarios also show that ordinary accesses and requests ignored while busy leave the reservation as it was, which the bench sees only through the outcome of a later store-conditional.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_LRSV  = 2'd2,
    KIND_SCOND = 2'd3
  } req_kind_e;

  typedef enum logic {
    ST_IDLE     = 1'b0,
    ST_WAIT_ACK = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/resv_store.sv
module resv_store #(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              resv_valid,
  output logic              hit
);
  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFFS_W;

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFFS_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (set_en) begin
      valid_q <= 1'b1;
      tag_q   <= line_tag(addr);
    end else if (clr_en) begin
      valid_q <= 1'b0;
    end
  end

  assign resv_valid = valid_q;
  assign hit        = valid_q && (tag_q == line_tag(addr));

  // R6: reset empties the reservation
  assert_reset_clears_R6: assert property (@(posedge clk) !rst_n |=> !resv_valid);
  // R2: load-reserve arms it
  assert_set_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> resv_valid);
  // R7: a store-conditional drops it
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !resv_valid);
  // R9: no set or clear keeps it
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(resv_valid));
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  req_kind_e req_kind,
  input  logic      hit,
  input  logic      bus_ack,
  output logic      busy,
  output logic      cache_wr_en,
  output logic      bus_start,
  output logic      resv_set,
  output logic      resv_clr,
  output logic      sc_cancel,
  output logic      done_valid,
  output logic      done_rc,
  output logic      done_stored
);
  ctrl_state_e state_q;
  logic        pend_sc_q;
  logic        accept;
  logic        write_go;
  logic        quick_done;

  assign accept     = req_valid && (state_q == ST_IDLE);
  assign write_go   = accept && ((req_kind == KIND_STORE) ||
                                 (req_kind == KIND_SCOND && hit));
  assign sc_cancel  = accept && (req_kind == KIND_SCOND) && !hit;
  assign quick_done = accept && ((req_kind == KIND_LOAD) ||
                                 (req_kind == KIND_LRSV) || sc_cancel);
  assign resv_set   = accept && (req_kind == KIND_LRSV);
  assign resv_clr   = accept && (req_kind == KIND_SCOND);
  assign cache_wr_en = write_go;
  assign bus_start   = write_go;
  assign busy        = (state_q == ST_WAIT_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_sc_q   <= 1'b0;
      done_valid  <= 1'b0;
      done_rc     <= 1'b0;
      done_stored <= 1'b0;
    end else begin
      done_valid  <= 1'b0;
      done_rc     <= 1'b0;
      done_stored <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (write_go) begin
            state_q   <= ST_WAIT_ACK;
            pend_sc_q <= (req_kind == KIND_SCOND);
          end else if (quick_done) begin
            done_valid <= 1'b1;
            done_rc    <= sc_cancel;
          end
        end
        default: begin
          if (bus_ack) begin
            state_q     <= ST_IDLE;
            done_valid  <= 1'b1;
            done_rc     <= pend_sc_q;
            done_stored <= pend_sc_q;
            pend_sc_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  // R3: a cancelled conditional store never writes
  assert_cancel_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_cancel |-> (!cache_wr_en && !bus_start));
  // R4: failure completes one cycle later
  assert_cancel_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_cancel |=> (done_valid && done_rc && !done_stored));
  // R5: stored is only reported with the condition-record flag
  assert_stored_has_rc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_stored |-> (done_valid && done_rc));
  // R8: an ordinary load completes without the condition-record flag
  assert_load_no_rc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == KIND_LOAD) |=> (done_valid && !done_rc));
  // R10: nothing starts while waiting
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cache_wr_en && !bus_start && !resv_set && !resv_clr));
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bus_ack,
  output logic              busy,
  output logic              cache_wr_en,
  output logic              bus_start,
  output logic              done_valid,
  output logic              done_rc,
  output logic              done_stored
);
  logic resv_set;
  logic resv_clr;
  logic resv_valid;
  logic hit;
  logic sc_cancel;

  resv_store #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .set_en(resv_set), .clr_en(resv_clr),
    .addr(req_addr), .resv_valid(resv_valid), .hit(hit)
  );

  resv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_kind(req_kind_e'(req_kind)), .hit(hit), .bus_ack(bus_ack),
    .busy(busy), .cache_wr_en(cache_wr_en), .bus_start(bus_start),
    .resv_set(resv_set), .resv_clr(resv_clr), .sc_cancel(sc_cancel),
    .done_valid(done_valid), .done_rc(done_rc), .done_stored(done_stored)
  );

  // R1: a match implies a live reservation
  assert_hit_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> resv_valid);
  // R3: cancel only when no write is permitted
  assert_cancel_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_cancel && cache_wr_en));
endmodule

// File: tb/sim_resv_tracker.sv
module sim_resv_tracker;
  localparam int CLK_P = 10;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_LR = 2'd2, K_SC = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [63:0] req_addr = '0;
  logic bus_ack = 1'b0;
  logic busy, cache_wr_en, bus_start, done_valid, done_rc, done_stored;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  resv_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .bus_ack(bus_ack), .busy(busy),
    .cache_wr_en(cache_wr_en), .bus_start(bus_start), .done_valid(done_valid),
    .done_rc(done_rc), .done_stored(done_stored)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request; checks write permission in the accept cycle and
  // the completion (or wait) one cycle later
  task automatic quick(input string tag, input logic [1:0] k, input logic [63:0] a,
                       input bit exp_rc);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    #1;
    chk({tag, " wr_en"}, int'(cache_wr_en), 0);
    chk({tag, " bus"}, int'(bus_start), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " done"}, int'(done_valid), 1);
    chk({tag, " rc"}, int'(done_rc), int'(exp_rc));
    chk({tag, " stored"}, int'(done_stored), 0);
  endtask

  task automatic writer(input string tag, input logic [1:0] k, input logic [63:0] a,
                        input bit exp_sc, input bit poke_busy, input logic [63:0] poke_a);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    #1;
    chk({tag, " wr_en"}, int'(cache_wr_en), 1);
    chk({tag, " bus"}, int'(bus_start), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " busy"}, int'(busy), 1);
    chk({tag, " early done"}, int'(done_valid), 0);
    if (poke_busy) begin
      req_valid = 1'b1; req_kind = K_LR; req_addr = poke_a;
      #1;
      chk({tag, " R10 no wr while busy"}, int'(cache_wr_en), 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " still waiting"}, int'(done_valid), 0);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    chk({tag, " done"}, int'(done_valid), 1);
    chk({tag, " rc"}, int'(done_rc), int'(exp_sc));
    chk({tag, " stored"}, int'(done_stored), int'(exp_sc));
    chk({tag, " idle"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 busy", int'(busy), 0);
    chk("R6 done", int'(done_valid), 0);
    rst_n = 1'b1;
    quick("R6 sc after reset fails", K_SC, 64'h1000, 1'b1);
  endtask

  task automatic t_success();
    quick("R2 lr", K_LR, 64'h2000_0040, 1'b0);
    writer("R5 sc hit", K_SC, 64'h2000_0078, 1'b1, 1'b0, '0);
    quick("R7 sc after success fails", K_SC, 64'h2000_0040, 1'b1);
  endtask

  task automatic t_miss();
    quick("R2 lr A", K_LR, 64'h3000_0000, 1'b0);
    quick("R3 R4 sc other line", K_SC, 64'h5000_0000, 1'b1);
    quick("R7 sc after failure fails", K_SC, 64'h3000_0000, 1'b1);
  endtask

  task automatic t_granule();
    quick("R1 lr", K_LR, 64'h4000_0080, 1'b0);
    quick("R1 next line misses", K_SC, 64'h4000_00C0, 1'b1);
    quick("R1 lr again", K_LR, 64'h4000_0080, 1'b0);
    writer("R1 offset bits ignored", K_SC, 64'h4000_00BF, 1'b1, 1'b0, '0);
    quick("R1 lr high", K_LR, 64'h8000_0000_0000_0000, 1'b0);
    quick("R1 top bit differs", K_SC, 64'h0, 1'b1);
  endtask

  task automatic t_ordinary();
    quick("R2 lr", K_LR, 64'h6000_0100, 1'b0);
    quick("R8 load no rc", K_LD, 64'h6000_0100, 1'b0);
    writer("R8 store no rc", K_ST, 64'h6000_0108, 1'b0, 1'b0, '0);
    writer("R9 sc still reserved", K_SC, 64'h6000_0100, 1'b1, 1'b0, '0);
  endtask

  task automatic t_replace();
    quick("R2 lr A", K_LR, 64'h7000_0000, 1'b0);
    quick("R2 lr B", K_LR, 64'h7100_0000, 1'b0);
    quick("R2 sc old line fails", K_SC, 64'h7000_0000, 1'b1);
    quick("R2 lr A again", K_LR, 64'h7000_0000, 1'b0);
    quick("R2 lr B again", K_LR, 64'h7100_0000, 1'b0);
    writer("R2 sc newest line", K_SC, 64'h7100_0010, 1'b1, 1'b0, '0);
  endtask

  task automatic t_busy();
    quick("R10 lr", K_LR, 64'h9000_0000, 1'b0);
    writer("R10 sc with poke", K_SC, 64'h9000_0000, 1'b1, 1'b1, 64'hA000_0000);
    quick("R10 ignored lr left no reservation", K_SC, 64'hA000_0000, 1'b1);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_success();
    t_miss();
    t_granule();
    t_ordinary();
    t_replace();
    t_busy();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule